// File: doc/BRIEF.md
# Pulse-Width Symbol Receiver for an Open-Drain Single-Wire Bus

This block listens on an open-drain, idle-high single-wire bus while the host expects the far end to answer. Each symbol begins with a falling edge. After the edge the line is sampled at four fixed offsets. The first offset at which the line is seen high decides the symbol: glitch, one, zero or break. If the line is still low at the last offset, the symbol is a stuck-bus fault. If no falling edge arrives within a programmable number of clocks, a timeout symbol is reported instead.

Data symbols are packed into a byte, least significant bit first. Any other symbol abandons the byte that is in progress, flags an error and starts the next byte afresh. The raw line first passes through a synchroniser. The four offsets are parameters counted in clocks, so a given bit rate is set by choosing them at instantiation.

Top module: `pulse_symbol_rx`

## Requirements
- R1: The raw line passes through a two-stage synchroniser before edge detection. While `enable` is low no symbol is classified, so `symValid` stays low.
- R2: While waiting for a falling edge, the wait counter increments each clock. When it reaches `timeoutLimit` with no edge, a symbol with code 5 (timeout) is reported. A falling edge seen in that same cycle takes priority over the timeout.
- R3: If the line is already high at offset `GLITCH_CYC` after the edge, the symbol has code 2 (glitch).
- R4: Otherwise, if the line is high at offset `ONE_CYC`, the symbol has code 1 (data one).
- R5: Otherwise, if the line is high at offset `ZERO_CYC`, the symbol has code 0 (data zero).
- R6: Otherwise, if the line is high at offset `BREAK_CYC`, the symbol has code 6 minus 3, that is code 3 (break).
- R7: If the line is still low at offset `BREAK_CYC`, the symbol has code 4 (bus fault).
- R8: Data symbols shift into the byte from the MSB end, so the first bit received ends up as bit 0. `byteValid` pulses for one clock, one clock after the `symValid` of the eighth data symbol, with the byte on `rxByte`.
- R9: A symbol with code 2 to 5 discards the partial byte and pulses `byteErr` one clock after its `symValid`. The next data symbol becomes bit 0 of a fresh byte.
- R10: Dropping `enable` discards any partial byte.
- R11: During reset, `symValid`, `byteValid` and `byteErr` are low and `rxByte` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receive window open |
| busIn | input | 1 | Raw bus level (asynchronous) |
| timeoutLimit | input | TMO_W | Clocks to wait for a falling edge |
| rxByte | output | DATA_W | Last assembled byte |
| byteValid | output | 1 | One-clock strobe: `rxByte` is new |
| byteErr | output | 1 | One-clock strobe: byte aborted by a non-data symbol |
| symValid | output | 1 | One-clock strobe per classified symbol |
| symCode | output | 3 | Symbol code (0 zero, 1 one, 2 glitch, 3 break, 4 fault, 5 timeout) |

## Verification
Two events can fall in the same clock: the wait counter reaching `timeoutLimit`, and a falling edge on the synchronised line. The bench provokes this with a short timeout. It reopens `enable` and sweeps the delay before the first falling edge across the cycles around the limit, so one step of the sweep lands the edge exactly on the expiry cycle. On every clock a behavioural reference model predicts `symValid`, `symCode`, `byteValid`, `rxByte` and `byteErr`. The edge must start a measurement in that cycle, and no timeout may be reported.

// File: rtl/psr_pkg.sv
`timescale 1ns/1ps
package psr_pkg;
  typedef enum logic [2:0] {
    SYM_ZERO    = 3'd0,
    SYM_ONE     = 3'd1,
    SYM_GLITCH  = 3'd2,
    SYM_BREAK   = 3'd3,
    SYM_BUSERR  = 3'd4,
    SYM_TIMEOUT = 3'd5
  } symCode_e;

  typedef struct packed {
    logic take;    // a data bit is ready
    logic bitVal;  // its value
    logic abort;   // non-data symbol: drop partial byte
    logic clear;   // receiver closed
  } rxStrobe_t;
endpackage

// File: rtl/psr_sync.sv
`timescale 1ns/1ps
module psr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe <= '1;
        else       pipe <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-2:0], d};
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/psr_ctrl.sv
`timescale 1ns/1ps
module psr_ctrl
  import psr_pkg::*;
#(
  parameter int TMO_W      = 16,
  parameter int GLITCH_CYC = 4,
  parameter int ONE_CYC    = 16,
  parameter int ZERO_CYC   = 32,
  parameter int BREAK_CYC  = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             busSync,
  input  logic [TMO_W-1:0] timeoutLimit,
  output logic             symValid,
  output symCode_e         symCode,
  output rxStrobe_t        strb
);
  localparam int MW = $clog2(BREAK_CYC + 1);
  localparam int CW = (TMO_W > MW) ? TMO_W : MW;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_MEAS} state_e;

  state_e   state, stNext;
  logic [CW-1:0] cnt, cntNext;
  logic     prevSync, fall, emit;
  symCode_e emitCode;
  logic     takeQ, bitQ, abortQ;

  assign fall = prevSync & ~busSync;

  always_comb begin
    emit     = 1'b0;
    emitCode = SYM_ZERO;
    stNext   = state;
    cntNext  = cnt;
    if (!enable) begin
      stNext  = ST_IDLE;
      cntNext = '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stNext  = ST_WAIT;
          cntNext = '0;
        end
        ST_WAIT: begin
          if (fall) begin
            stNext  = ST_MEAS;
            cntNext = CW'(1);
          end else if (cnt >= CW'(timeoutLimit)) begin
            emit     = 1'b1;
            emitCode = SYM_TIMEOUT;
            cntNext  = '0;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_MEAS: begin
          cntNext = cnt + 1'b1;
          if (cnt == CW'(GLITCH_CYC) && busSync) begin
            emit = 1'b1; emitCode = SYM_GLITCH;
          end else if (cnt == CW'(ONE_CYC) && busSync) begin
            emit = 1'b1; emitCode = SYM_ONE;
          end else if (cnt == CW'(ZERO_CYC) && busSync) begin
            emit = 1'b1; emitCode = SYM_ZERO;
          end else if (cnt == CW'(BREAK_CYC)) begin
            emit = 1'b1; emitCode = busSync ? SYM_BREAK : SYM_BUSERR;
          end
          if (emit) begin
            stNext  = ST_WAIT;
            cntNext = '0;
          end
        end
        default: begin
          stNext  = ST_IDLE;
          cntNext = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      prevSync <= 1'b1;
      symValid <= 1'b0;
      symCode  <= SYM_ZERO;
      takeQ    <= 1'b0;
      bitQ     <= 1'b0;
      abortQ   <= 1'b0;
    end else begin
      state    <= stNext;
      cnt      <= cntNext;
      prevSync <= busSync;
      symValid <= emit;
      if (emit) symCode <= emitCode;
      takeQ    <= emit && (emitCode == SYM_ZERO || emitCode == SYM_ONE);
      bitQ     <= emit && (emitCode == SYM_ONE);
      abortQ   <= emit && !(emitCode == SYM_ZERO || emitCode == SYM_ONE);
    end
  end

  assign strb = '{take: takeQ, bitVal: bitQ, abort: abortQ, clear: (state == ST_IDLE)};

  // R1: a closed window never produces a symbol
  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !symValid);
  // R2: timeout is only reported from the edge-wait phase
  a_r2_timeout_from_wait: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && symCode == SYM_TIMEOUT) |-> $past(state) == ST_WAIT);
  // R3: glitch decided at the first sampling offset with the line high
  a_r3_glitch_offset: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && symCode == SYM_GLITCH) |-> ($past(cnt) == CW'(GLITCH_CYC) && $past(busSync)));
  // R4: a one is decided at the second offset with the line high
  a_r4_one_offset: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && symCode == SYM_ONE) |-> ($past(cnt) == CW'(ONE_CYC) && $past(busSync)));
  // R7: a measurement never runs past the last offset
  a_r7_meas_window: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MEAS) |-> (cnt != '0 && cnt <= CW'(BREAK_CYC)));
endmodule

// File: rtl/psr_dpath.sv
`timescale 1ns/1ps
module psr_dpath
  import psr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteValid,
  output logic              byteErr
);
  localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] shreg, shNext;
  logic [BCW-1:0]    bitCnt;

  assign shNext = {strb.bitVal, shreg[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg     <= '0;
      bitCnt    <= '0;
      rxByte    <= '0;
      byteValid <= 1'b0;
      byteErr   <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      byteErr   <= 1'b0;
      if (strb.clear) begin
        bitCnt <= '0;
      end else begin
        if (strb.take) begin
          shreg <= shNext;
          if (bitCnt == BCW'(DATA_W - 1)) begin
            rxByte    <= shNext;
            byteValid <= 1'b1;
            bitCnt    <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        if (strb.abort) begin
          bitCnt  <= '0;
          byteErr <= 1'b1;
        end
      end
    end
  end

  // R8: a completed byte always follows an accepted data bit
  a_r8_byte_needs_bit: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(strb.take));
  // R9: a non-data symbol flags an error and restarts the byte
  a_r9_abort_restarts: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> (byteErr && bitCnt == '0));
  // R10: a closed window empties the partial byte
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (bitCnt == '0 && !byteValid));
endmodule

// File: rtl/pulse_symbol_rx.sv
`timescale 1ns/1ps
module pulse_symbol_rx
  import psr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC  = 4,
  parameter int ONE_CYC     = 16,
  parameter int ZERO_CYC    = 32,
  parameter int BREAK_CYC   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              busIn,
  input  logic [TMO_W-1:0]  timeoutLimit,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteValid,
  output logic              byteErr,
  output logic              symValid,
  output logic [2:0]        symCode
);
  logic      busSync;
  symCode_e  codeE;
  rxStrobe_t strb;

  psr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .d(busIn), .q(busSync)
  );

  psr_ctrl #(
    .TMO_W(TMO_W), .GLITCH_CYC(GLITCH_CYC), .ONE_CYC(ONE_CYC),
    .ZERO_CYC(ZERO_CYC), .BREAK_CYC(BREAK_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .busSync(busSync),
    .timeoutLimit(timeoutLimit), .symValid(symValid), .symCode(codeE), .strb(strb)
  );

  psr_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxByte(rxByte), .byteValid(byteValid), .byteErr(byteErr)
  );

  assign symCode = codeE;
endmodule

// File: tb/tb_pulse_symbol_rx.sv
`timescale 1ns/1ps
module tb_pulse_symbol_rx;
  localparam int GL = 4, ONE = 16, ZER = 32, BRK = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        busIn = 1'b1;
  logic [15:0] timeoutLimit = 16'd1000;
  logic [7:0]  rxByte;
  logic        byteValid, byteErr, symValid;
  logic [2:0]  symCode;

  int checks = 0, fails = 0;
  bit done = 0;

  pulse_symbol_rx dut (
    .clk(clk), .rstN(rstN), .enable(enable), .busIn(busIn),
    .timeoutLimit(timeoutLimit), .rxByte(rxByte), .byteValid(byteValid),
    .byteErr(byteErr), .symValid(symValid), .symCode(symCode)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input int code);
    case (code)
      0: return "R5";
      1: return "R4";
      2: return "R3";
      3: return "R6";
      4: return "R7";
      default: return "R2";
    endcase
  endfunction

  // Behavioural reference model, advanced on every rising edge
  int  mState, mCnt, mCode, mBitCnt, code;
  bit  mL1, mL2, mPrev, mSymV, mTake, mBitV, mAbort, mByteV, mErrV, bs, fl, em;
  logic [7:0] mSh, mByte;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mCode = 0; mBitCnt = 0;
      mL1 = 1; mL2 = 1; mPrev = 1; mSymV = 0; mTake = 0; mBitV = 0;
      mAbort = 0; mByteV = 0; mErrV = 0; mSh = 0; mByte = 0;
    end else begin
      bs = mL2;
      fl = mPrev && !bs;
      mByteV = 0; mErrV = 0;
      if (mState == 0) mBitCnt = 0;
      else begin
        if (mTake) begin
          mSh = {mBitV, mSh[7:1]};
          if (mBitCnt == 7) begin mByte = mSh; mByteV = 1; mBitCnt = 0; end
          else mBitCnt++;
        end
        if (mAbort) begin mBitCnt = 0; mErrV = 1; end
      end
      em = 0; code = 0;
      if (!enable) begin mState = 0; mCnt = 0; end
      else if (mState == 0) begin mState = 1; mCnt = 0; end
      else if (mState == 1) begin
        if (fl) begin mState = 2; mCnt = 1; end
        else if (mCnt >= int'(timeoutLimit)) begin em = 1; code = 5; mCnt = 0; end
        else mCnt++;
      end else begin
        if (mCnt == GL && bs) begin em = 1; code = 2; end
        else if (mCnt == ONE && bs) begin em = 1; code = 1; end
        else if (mCnt == ZER && bs) begin em = 1; code = 0; end
        else if (mCnt == BRK) begin em = 1; code = bs ? 3 : 4; end
        if (em) begin mState = 1; mCnt = 0; end
        else mCnt++;
      end
      mSymV = em;
      if (em) mCode = code;
      mTake = em && code < 2;
      mBitV = em && code == 1;
      mAbort = em && code >= 2;
      mPrev = bs; mL2 = mL1; mL1 = busIn;
    end
  end

  // Per-clock comparison and event monitor
  int lastCode = -1, symCount = 0, byteCount = 0, errCount = 0;
  logic [7:0] lastByte = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (symValid || mSymV) begin
        chk(symValid == mSymV && (!mSymV || int'(symCode) == mCode),
            reqOf(mSymV ? mCode : int'(symCode)), "symbol",
            symValid ? int'(symCode) : -1, mSymV ? mCode : -1);
      end
      if (byteValid || mByteV)
        chk(byteValid == mByteV && (!mByteV || rxByte == mByte), "R8", "byte",
            byteValid ? int'(rxByte) : -1, mByteV ? int'(mByte) : -1);
      if (byteErr || mErrV)
        chk(byteErr == mErrV, "R9", "byte error strobe", int'(byteErr), int'(mErrV));
      if (symValid) begin lastCode = int'(symCode); symCount++; end
      if (byteValid) begin lastByte = rxByte; byteCount++; end
      if (byteErr) errCount++;
    end
  end

  task automatic pulse(input int lo, input int hi);
    busIn = 1'b0;
    repeat (lo) @(negedge clk);
    busIn = 1'b1;
    repeat (hi) @(negedge clk);
  endtask

  task automatic sendBit(input bit b);
    pulse(b ? 10 : 24, 40);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(v[i]);
  endtask

  task automatic expectByte(input logic [7:0] v, input string req);
    int b0;
    b0 = byteCount;
    sendByte(v);
    repeat (4) @(negedge clk);
    chk(byteCount == b0 + 1, req, "bytes completed", byteCount - b0, 1);
    chk(lastByte == v, req, "byte value", int'(lastByte), int'(v));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    int s0, e0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!symValid && !byteValid && !byteErr, "R11", "strobes in reset",
        int'({symValid, byteValid, byteErr}), 0);
    chk(rxByte == 8'h00, "R11", "byte in reset", int'(rxByte), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    repeat (4) @(negedge clk);

    expectByte(8'hA5, "R8");
    expectByte(8'h3C, "R8");

    // R4 / R5 single symbols
    sendBit(1'b1);
    chk(lastCode == 1, "R4", "one code", lastCode, 1);
    sendBit(1'b0);
    chk(lastCode == 0, "R5", "zero code", lastCode, 0);
    // flush the partial byte with a glitch (R3) and check the abort (R9)
    e0 = errCount;
    pulse(2, 40);
    chk(lastCode == 2, "R3", "glitch code", lastCode, 2);
    chk(errCount == e0 + 1, "R9", "abort strobes", errCount - e0, 1);

    // R9: partial byte then glitch, next byte starts clean
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    pulse(2, 40);
    expectByte(8'h81, "R9");

    // R6 break and R7 stuck bus
    pulse(48, 40);
    chk(lastCode == 3, "R6", "break code", lastCode, 3);
    pulse(100, 40);
    chk(lastCode == 4, "R7", "bus fault code", lastCode, 4);

    // R10: closing the window discards a partial byte
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b1); sendBit(1'b1);
    enable = 1'b0;
    repeat (5) @(negedge clk);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    expectByte(8'h5A, "R10");

    // R1: pulses while disabled are ignored
    enable = 1'b0;
    s0 = symCount;
    pulse(10, 40); pulse(24, 40); pulse(2, 40);
    chk(symCount == s0, "R1", "symbols while disabled", symCount - s0, 0);

    // R2: timeout on an idle line
    timeoutLimit = 16'd50;
    enable = 1'b1;
    s0 = symCount;
    repeat (120) @(negedge clk);
    chk(symCount > s0 && lastCode == 5, "R2", "timeout code", lastCode, 5);

    // R2: edge arriving around timeout expiry, judged by the model
    timeoutLimit = 16'd30;
    for (int d = 24; d <= 38; d++) begin
      enable = 1'b0;
      repeat (3) @(negedge clk);
      enable = 1'b1;
      repeat (d) @(negedge clk);
      pulse(10, 20);
    end
    timeoutLimit = 16'd1000;
    enable = 1'b0;
    repeat (10) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule